// File: doc/BRIEF.md
# Four-Mode Timer with Reload

This block is a timer built from two byte-wide count registers, a low byte and a high byte. A two-bit mode setting changes how the two bytes are chained. Mode 0 uses the five least significant bits of the low byte as a divide-by-32 prescaler that feeds the high byte. Mode 1 joins the two bytes into one sixteen-bit counter. Mode 2 counts in the low byte alone and refills it from the high byte each time it wraps. Mode 3 freezes both bytes.

Counting advances by at most one step per clock. A step happens only when the software run bit is set, the count-enable input is high and the mode is not 3. When the active chain wraps, an overflow flag is set. The flag is cleared by an interrupt acknowledge pulse, or software can write it directly. The interrupt request is the flag qualified by a per-timer enable and a global enable. Software writes and reads both count bytes, the mode, the run bit and the flag through plain write-enable and data ports.

Top module: `mode_timer`

## Requirements
- R1: A synchronous active-high reset clears both count bytes, the mode (to 0), the run bit and the overflow flag.
- R2: In mode 0 (mode value 2'b00), each step increments bits [4:0] of the low byte modulo 32. A step from 31 to 0 also increments the high byte. Bits [7:5] of the low byte keep their last written value.
- R3: In mode 1 (2'b01), each step increments the 16-bit value {high byte, low byte} by one, wrapping from 16'hFFFF to 0.
- R4: In mode 2 (2'b10), a step increments the low byte. A step from 8'hFF loads the low byte with the high byte instead.
- R5: In mode 2 the high byte changes only through a software write; a reload leaves it unchanged.
- R6: In mode 3 (2'b11) neither count byte changes except by software write, whatever the run bit is.
- R7: No step occurs while the run bit is 0 or the count-enable input is low.
- R8: The overflow flag is set one cycle after a step in which the active chain carries out: from the high byte at 8'hFF with prescaler 31 in mode 0, from 16'hFFFF in mode 1, and from the low byte at 8'hFF in mode 2.
- R9: An acknowledge pulse clears the flag on the next cycle. If a flag set occurs in the same cycle, the set wins.
- R10: The interrupt request is high exactly when the flag, the per-timer enable and the global enable are all 1.
- R11: A software write to a count byte in the same cycle as a step stores the written value.
- R12: A software flag write loads the written value unless an overflow occurs in the same cycle. The write takes precedence over an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one step per cycle while high |
| ctl_we | input | 1 | Writes run bit and mode |
| ctl_run_wd | input | 1 | Run bit write data |
| ctl_mode_wd | input | 2 | Mode write data |
| lo_we | input | 1 | Low byte write enable |
| lo_wd | input | 8 | Low byte write data |
| hi_we | input | 1 | High byte write enable |
| hi_wd | input | 8 | High byte write data |
| flg_we | input | 1 | Overflow flag write enable |
| flg_wd | input | 1 | Overflow flag write data |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| tmr_ie | input | 1 | Per-timer interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| lo_q | output | 8 | Low byte value |
| hi_q | output | 8 | High byte value |
| mode_q | output | 2 | Current mode |
| run_q | output | 1 | Current run bit |
| ovf_q | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench seeds count bytes with values near 8'hFF and 5'd31 so that prescaler wraps, sixteen-bit carries and mode-2 reloads happen often. A design that let the prescaler spill into bits [7:5] would corrupt them. One that reloaded by copying the low byte into the high byte would change the high byte, and one that counted the low byte from the wrong width in mode 0 would raise overflow at the wrong time. Writes are made to collide with steps, and acknowledges with overflows. This exposes a design that lets the step override a write or lets an acknowledge swallow a fresh overflow. Halt mode is tried with the run bit set, so that a design that only honoured the run bit would be seen counting.

// File: rtl/mode_timer.sv
module mode_timer #(
  parameter int W  = 8,
  parameter int PS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         ctl_we,
  input  logic         ctl_run_wd,
  input  logic [1:0]   ctl_mode_wd,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wd,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wd,
  input  logic         flg_we,
  input  logic         flg_wd,
  input  logic         irq_ack,
  input  logic         tmr_ie,
  input  logic         glb_ie,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic [1:0]   mode_q,
  output logic         run_q,
  output logic         ovf_q,
  output logic         irq
);
  localparam int DW = 2 * W;

  logic [W-1:0] lo_n, hi_n;
  logic         carry;
  logic         tick;

  assign tick = run_q & cnt_en & (mode_q != 2'd3);
  assign irq  = ovf_q & tmr_ie & glb_ie;

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    carry = 1'b0;
    if (tick) begin
      case (mode_q)
        2'd0: begin
          lo_n[PS-1:0] = lo_q[PS-1:0] + PS'(1);
          if (&lo_q[PS-1:0]) begin
            hi_n  = hi_q + W'(1);
            carry = &hi_q;
          end
        end
        2'd1: begin
          {hi_n, lo_n} = {hi_q, lo_q} + DW'(1);
          carry        = &{hi_q, lo_q};
        end
        2'd2: begin
          if (&lo_q) begin
            lo_n  = hi_q;
            carry = 1'b1;
          end else begin
            lo_n = lo_q + W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= 2'd0;
      run_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      lo_q <= lo_we ? lo_wd : lo_n;
      hi_q <= hi_we ? hi_wd : hi_n;
      if (ctl_we) begin
        mode_q <= ctl_mode_wd;
        run_q  <= ctl_run_wd;
      end
      if (carry)        ovf_q <= 1'b1;
      else if (flg_we)  ovf_q <= flg_wd;
      else if (irq_ack) ovf_q <= 1'b0;
    end
  end

  p_hi_hold_m2_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2 && !hi_we) |=> $stable(hi_q));

  p_halt_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd3 && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q)));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ((!run_q || !cnt_en) && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q)));

  p_top_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && !lo_we) |=> $stable(lo_q[W-1:PS]));

  p_reload_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2 && run_q && cnt_en && (&lo_q)) |=> ovf_q);

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !flg_we && !cnt_en) |=> !ovf_q);

  p_irq_flag_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ovf_q && tmr_ie && glb_ie));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (lo_q == $past(lo_wd)));
endmodule

// File: tb/mode_timer_tb_top.sv
module mode_timer_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic cnt_en, ctl_we, ctl_run_wd, lo_we, hi_we, flg_we, flg_wd, irq_ack, tmr_ie, glb_ie;
  logic [1:0] ctl_mode_wd;
  logic [7:0] lo_wd, hi_wd;
  logic [7:0] lo_q, hi_q;
  logic [1:0] mode_q;
  logic run_q, ovf_q, irq;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_lo, m_hi;
  logic [1:0] m_mode;
  logic m_run, m_ovf;
  string t_lo, t_hi, t_f;

  always #2 clk = ~clk;

  mode_timer dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte();
    case ($urandom % 5)
      0: return 8'hFF;
      1: return 8'hFE;
      2: return 8'h1F;
      3: return 8'h3E;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic step();
    logic tk, cy;
    logic [7:0] nl, nh;
    logic [15:0] w;
    tk = m_run & cnt_en & (m_mode != 2'd3);
    nl = m_lo; nh = m_hi; cy = 1'b0;
    t_lo = !tk ? (m_mode == 2'd3 ? "R6" : "R7") : "R2";
    if (tk) begin
      case (m_mode)
        2'd0: begin
          nl = {m_lo[7:5], 5'(m_lo[4:0] + 5'd1)};
          if (m_lo[4:0] == 5'd31) begin nh = m_hi + 8'd1; cy = (m_hi == 8'hFF); end
          t_lo = "R2";
        end
        2'd1: begin
          w = {m_hi, m_lo} + 16'd1; {nh, nl} = w; cy = ({m_hi, m_lo} == 16'hFFFF);
          t_lo = "R3";
        end
        default: begin
          if (m_lo == 8'hFF) begin nl = m_hi; cy = 1'b1; end else nl = m_lo + 8'd1;
          t_lo = "R4";
        end
      endcase
    end
    t_hi = (m_mode == 2'd2) ? "R5" : t_lo;
    if (lo_we) begin nl = lo_wd; t_lo = "R11"; end
    if (hi_we) begin nh = hi_wd; t_hi = "R11"; end
    t_f = cy ? "R8" : flg_we ? "R12" : irq_ack ? "R9" : "R8";
    if (cy) m_ovf = 1'b1;
    else if (flg_we) m_ovf = flg_wd;
    else if (irq_ack) m_ovf = 1'b0;
    m_lo = nl; m_hi = nh;
    if (ctl_we) begin m_mode = ctl_mode_wd; m_run = ctl_run_wd; end
    @(posedge clk);
    @(negedge clk);
    chk(t_lo, lo_q, m_lo);
    chk(t_hi, hi_q, m_hi);
    chk(t_f, ovf_q, m_ovf);
    chk("R1", {mode_q, run_q}, {m_mode, m_run});
    chk("R10", irq, m_ovf & tmr_ie & glb_ie);
    idle();
  endtask

  task automatic idle();
    cnt_en = 0; ctl_we = 0; lo_we = 0; hi_we = 0; flg_we = 0; irq_ack = 0;
  endtask

  task automatic setup(logic [1:0] md, logic rn, logic [7:0] l, logic [7:0] h);
    ctl_we = 1; ctl_mode_wd = md; ctl_run_wd = rn;
    lo_we = 1; lo_wd = l; hi_we = 1; hi_wd = h;
    step();
  endtask

  initial begin
    idle();
    ctl_run_wd = 0; ctl_mode_wd = 0; lo_wd = 0; hi_wd = 0; flg_wd = 0;
    tmr_ie = 1; glb_ie = 1;
    void'($urandom(32'd1234));
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1", {lo_q, hi_q, mode_q, run_q, ovf_q}, 0);
    m_lo = 0; m_hi = 0; m_mode = 0; m_run = 0; m_ovf = 0;

    // R2: prescaler wrap with nonzero upper bits, high byte at FF -> overflow
    setup(2'd0, 1'b1, 8'hBF, 8'hFF);
    cnt_en = 1; step();
    chk("R2", lo_q, 8'hA0);
    chk("R8", ovf_q, 1);
    // R9: ack clears
    irq_ack = 1; step();
    chk("R9", ovf_q, 0);
    // R3: 16-bit carry
    setup(2'd1, 1'b1, 8'hFF, 8'hFF);
    cnt_en = 1; irq_ack = 1; step();
    chk("R3", {hi_q, lo_q}, 0);
    chk("R9", ovf_q, 1);
    // R4/R5: reload from high byte
    flg_we = 1; flg_wd = 0; setup(2'd2, 1'b1, 8'hFF, 8'h5A);
    cnt_en = 1; step();
    chk("R4", lo_q, 8'h5A);
    chk("R5", hi_q, 8'h5A);
    // R12: flag write beats ack
    flg_we = 1; flg_wd = 1; irq_ack = 1; step();
    chk("R12", ovf_q, 1);
    // R6: halt with run set
    setup(2'd3, 1'b1, 8'h10, 8'h20);
    cnt_en = 1; step();
    chk("R6", {hi_q, lo_q}, 16'h2010);
    // R7: run bit off
    setup(2'd1, 1'b0, 8'h10, 8'h20);
    cnt_en = 1; step();
    chk("R7", lo_q, 8'h10);
    // R11: write collides with a step
    setup(2'd1, 1'b1, 8'h10, 8'h20);
    cnt_en = 1; lo_we = 1; lo_wd = 8'h77; step();
    chk("R11", lo_q, 8'h77);

    for (int i = 0; i < 8000; i++) begin
      cnt_en = ($urandom % 4) != 0;
      tmr_ie = $urandom % 2; glb_ie = ($urandom % 4) != 0;
      if ($urandom % 48 == 0) begin ctl_we = 1; ctl_mode_wd = 2'($urandom); ctl_run_wd = ($urandom % 6) != 0; end
      if ($urandom % 20 == 0) begin lo_we = 1; lo_wd = rbyte(); end
      if ($urandom % 20 == 0) begin hi_we = 1; hi_wd = rbyte(); end
      if ($urandom % 24 == 0) begin flg_we = 1; flg_wd = $urandom % 2; end
      irq_ack = ($urandom % 10) == 0;
      step();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule